// File: doc/BRIEF.md
# Idle Wake Timer

This block is a free-running down counter driven by a slow timebase. It is meant to bring a processor out of an idle low-power state after a chosen interval. Software never sees or touches the count. The count cannot be loaded, read, started or stopped. Its only observable effect is a periodic event, taken where one selectable tap bit of the counter borrows, so that the bit goes from 0 to 1.

Each event sets a sticky pending flag and fires a one-cycle wake pulse. The pending flag, gated by an interrupt enable, forms the interrupt request. The power controller stops the counter with a run-enable input, for example during low-speed halt.

The window select picks the tap. Switching it can compare a 0 on the old tap with a 1 on the new one, which produces a false event. Software should therefore mask the interrupt while it changes the window, and then clear the flag. The count after reset is left to a parameter, so an idle entry that is not aligned to an event can wake at any point up to one full window.

Top module: `idle_wake_timer`

## Requirements
- R1: While `rst` is high, and on the cycle after it falls, `pend`, `wake` and `irq` are 0. The counter holds the parameter `SEED`.
- R2: On each clock with `run_en`=1 the counter decrements by one, wrapping modulo 2^CNT_W. With `run_en`=0 it holds its value, so a static window select produces no event.
- R3: Window select value s picks tap bit k = TAP_BASE + TAP_STEP*s. While the counter runs, successive events are 2^(k+1) cycles apart.
- R4: An event occurs when the selected tap is 0 in one cycle and 1 in the next. The edge after the event sets `pend`. Starting from `SEED` and running, the first event sets `pend` and `wake` at the ((SEED mod 2^(k+1)) + 2)-th clock edge after reset falls.
- R5: A change of `win_sel` from a tap that reads 0 to a tap that reads 1 is an event, even with the counter stopped. A change from a 1 tap to any tap is not an event.
- R6: `pend` stays 1 until a cycle with `pend_clr`=1 and no event. `pend` is 0 after that edge.
- R7: If `pend_clr` and an event occur in the same cycle, `pend` is 1 after the edge.
- R8: `irq` equals `pend` AND `irq_en`, in the same cycle, with no register between them.
- R9: `wake` is high for exactly the one cycle after each event edge, which is the cycle in which `pend` is set by that event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow timebase clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Counter runs when 1 (from the power controller) |
| win_sel | input | 2 | Window select, chooses the tap bit |
| irq_en | input | 1 | Interrupt enable |
| pend_clr | input | 1 | Write-one-to-clear strobe for the pending flag |
| pend | output | 1 | Sticky pending flag |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | One-cycle wake pulse that ends idle |

## Verification
An event forms in the cycle after the count or select change that raises the tap. `pend` and `wake` appear one edge later. A clear takes effect one edge after it is applied, and `irq` follows `pend` and `irq_en` with no delay. The bench drives inputs and samples `pend` and `wake` at falling edges, counting rising edges so that each expected edge number is derived from the seed and the tap. It checks `irq` a short delay after changing `irq_en`. Window-change and collision cases run with the counter stopped, so that the tap values are known from the seed.

// File: rtl/iwt_pkg.sv
package iwt_pkg;

    localparam int SEL_W   = 2;
    localparam int NUM_WIN = 1 << SEL_W;

    function automatic int tap_bit(input int base, input int step, input int idx);
        return base + step * idx;
    endfunction

    typedef struct packed {
        logic pend;
        logic wake;
    } iwt_flags_t;

endpackage

// File: rtl/iwt_down_counter.sv
module iwt_down_counter
    import iwt_pkg::*;
#(
    parameter int               CNT_W    = 16,
    parameter int               TAP_BASE = 9,
    parameter int               TAP_STEP = 2,
    parameter logic [CNT_W-1:0] SEED     = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run_en,
    output logic [NUM_WIN-1:0] taps
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= SEED;
        else if (run_en)
            cnt_q <= cnt_q - ONE;
    end

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_tap
        assign taps[i] = cnt_q[tap_bit(TAP_BASE, TAP_STEP, i)];
    end

    // R2
    hold_when_stopped_chk: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> $stable(cnt_q));

    // R2
    step_down_chk: assert property (@(posedge clk) disable iff (rst)
        run_en |=> cnt_q == $past(cnt_q) - ONE);

endmodule

// File: rtl/iwt_win_edge.sv
module iwt_win_edge
    import iwt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_WIN-1:0] taps,
    input  logic [SEL_W-1:0]   win_sel,
    output logic               evt
);

    logic cur_tap;
    logic prev_tap_q;

    assign cur_tap = taps[win_sel];

    always_ff @(posedge clk) begin
        if (rst)
            prev_tap_q <= 1'b1;
        else
            prev_tap_q <= cur_tap;
    end

    assign evt = cur_tap & ~prev_tap_q;

    // R5
    stable_low_no_evt_chk: assert property (@(posedge clk) disable iff (rst)
        $stable(win_sel) && $stable(taps) |-> !evt);

endmodule

// File: rtl/iwt_pend_ctrl.sv
module iwt_pend_ctrl
    import iwt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic evt,
    input  logic pend_clr,
    input  logic irq_en,
    output logic pend,
    output logic wake,
    output logic irq
);

    iwt_flags_t flags_q;
    iwt_flags_t flags_d;

    always_comb begin
        flags_d.wake = evt;
        flags_d.pend = evt | (flags_q.pend & ~pend_clr);
    end

    always_ff @(posedge clk) begin
        if (rst)
            flags_q <= '0;
        else
            flags_q <= flags_d;
    end

    assign pend = flags_q.pend;
    assign wake = flags_q.wake;
    assign irq  = flags_q.pend & irq_en;

    // R6
    clear_drops_chk: assert property (@(posedge clk) disable iff (rst)
        pend_clr && !evt |=> !pend);

    // R6
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        pend && !pend_clr |=> pend);

    // R7
    collision_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        pend_clr && evt |=> pend);

    // R9
    wake_with_pend_chk: assert property (@(posedge clk) disable iff (rst)
        wake |-> pend);

endmodule

// File: rtl/idle_wake_timer.sv
module idle_wake_timer
    import iwt_pkg::*;
#(
    parameter int               CNT_W    = 16,
    parameter int               TAP_BASE = 9,
    parameter int               TAP_STEP = 2,
    parameter logic [CNT_W-1:0] SEED     = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic [SEL_W-1:0] win_sel,
    input  logic             irq_en,
    input  logic             pend_clr,
    output logic             pend,
    output logic             irq,
    output logic             wake
);

    logic [NUM_WIN-1:0] taps;
    logic               evt;

    iwt_down_counter #(
        .CNT_W    (CNT_W),
        .TAP_BASE (TAP_BASE),
        .TAP_STEP (TAP_STEP),
        .SEED     (SEED)
    ) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .run_en (run_en),
        .taps   (taps)
    );

    iwt_win_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .taps    (taps),
        .win_sel (win_sel),
        .evt     (evt)
    );

    iwt_pend_ctrl u_pend (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .pend_clr (pend_clr),
        .irq_en   (irq_en),
        .pend     (pend),
        .wake     (wake),
        .irq      (irq)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> !pend && !wake);

    // R4
    event_sets_chk: assert property (@(posedge clk) disable iff (rst)
        evt |=> pend && wake);

    // R8
    irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !irq);

    // R8
    irq_needs_pend_chk: assert property (@(posedge clk) disable iff (rst)
        !pend |-> !irq);

endmodule

// File: tb/idle_wake_timer_tb.sv
module idle_wake_timer_tb;

    localparam int             CNT_W    = 8;
    localparam int             TAP_BASE = 1;
    localparam int             TAP_STEP = 2;
    localparam logic [7:0]     SEED     = 8'hA5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run_en = 1'b0;
    logic [1:0] win_sel = 2'd0;
    logic       irq_en = 1'b0;
    logic       pend_clr = 1'b0;
    logic       pend, irq, wake;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    idle_wake_timer #(
        .CNT_W    (CNT_W),
        .TAP_BASE (TAP_BASE),
        .TAP_STEP (TAP_STEP),
        .SEED     (SEED)
    ) u_dut (
        .clk      (clk),
        .rst      (rst),
        .run_en   (run_en),
        .win_sel  (win_sel),
        .irq_en   (irq_en),
        .pend_clr (pend_clr),
        .pend     (pend),
        .irq      (irq),
        .wake     (wake)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic run);
        @(negedge clk);
        rst = 1'b1; run_en = run; win_sel = 2'd0; irq_en = 1'b0; pend_clr = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_wake(output int n);
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end while (!wake && n < 2000);
    endtask

    // R1: outputs quiet during and right after reset, even with irq_en set
    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1; run_en = 1'b1; irq_en = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 pend in reset", pend, 0);
        chk("R1 wake in reset", wake, 0);
        chk("R1 irq in reset", irq, 0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R1 pend after reset", pend, 0);
        chk("R1 irq after reset", irq, 0);
    endtask

    // R4: first event position from the seed, tap 1 (period 4)
    task automatic t_first_event();
        int n;
        do_reset(1'b1);
        wait_wake(n);
        chk("R4 first wake edge", n, (SEED % 4) + 2);
        chk("R4 pend with first wake", pend, 1);
    endtask

    // R3 and R9: period per window and one-cycle wake
    task automatic t_period(input int s);
        int n;
        int k;
        k = TAP_BASE + TAP_STEP * s;
        @(negedge clk);
        win_sel = 2'(s);
        wait_wake(n);
        wait_wake(n);
        wait_wake(n);
        chk($sformatf("R3 period sel=%0d", s), n, 1 << (k + 1));
        @(posedge clk);
        @(negedge clk);
        chk($sformatf("R9 wake one cycle sel=%0d", s), wake, 0);
    endtask

    // R2, R5, R6, R7, R8 with counter stopped at SEED (taps: b1=0 b3=0 b5=1 b7=1)
    task automatic t_frozen();
        int seen;
        do_reset(1'b0);
        seen = 0;
        for (int i = 0; i < 40; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (pend || wake) seen++;
        end
        chk("R2 no event while stopped", seen, 0);
        // R5: switch tap reading 0 to tap reading 1
        win_sel = 2'd2;
        @(posedge clk);
        @(negedge clk);
        chk("R5 spurious pend on window change", pend, 1);
        chk("R5 spurious wake on window change", wake, 1);
        @(posedge clk);
        @(negedge clk);
        chk("R9 wake drops after one cycle", wake, 0);
        // R5: switch from 1 tap to 0 tap is no event; R6 sticky
        win_sel = 2'd0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk("R6 pend sticky without clear", pend, 1);
        chk("R5 no wake on 1-to-0 change", wake, 0);
        pend_clr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        pend_clr = 1'b0;
        chk("R6 pend cleared", pend, 0);
        irq_en = 1'b1;
        #1;
        chk("R8 irq low with pend low", irq, 0);
        @(negedge clk);
        irq_en = 1'b0;
        // R7: clear and event together
        pend_clr = 1'b1;
        win_sel = 2'd2;
        @(posedge clk);
        @(negedge clk);
        pend_clr = 1'b0;
        chk("R7 collision leaves pend set", pend, 1);
        chk("R8 irq masked", irq, 0);
        irq_en = 1'b1;
        #1;
        chk("R8 irq follows enable", irq, 1);
        irq_en = 1'b0;
        #1;
        chk("R8 irq drops with enable", irq, 0);
    endtask

    initial begin
        #1_500_000;
        checks++;
        fails++;
        $display("FAIL watchdog all requirements actual=timeout expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_first_event();
        for (int s = 0; s < 4; s++) t_period(s);
        t_frozen();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule